// File: doc/BRIEF.md
# Two-Bank Relay Step Sequencer

This block drives sixteen relay coil lines from two chained banks of eight stages each. The lower bank feeds relay lines 50 to 57 and the upper bank feeds relay lines 60 to 67. The last stage of the lower bank feeds the first stage of the upper bank, so a single active bit can travel along both banks as one chain.

A start pulse places one active bit in the first stage of the lower bank. After that, each cycle with the step input high moves the active bit up by one stage. When the bit reaches the loop tap (relay line 65, upper bank bit 5), the next step clears the upper bank and puts the bit back into stage 0 of the lower bank in the same edge. The sequence therefore repeats every 14 steps, without any outside help, until a reset or a new start.

Top module: `relay_step_seq`

## Requirements
- R1: A synchronous active-high `rst` clears all sixteen relay outputs at the next clock edge. `rst` overrides `start` and `step`.
- R2: A cycle with `start` high and `rst` low loads `relay_lo` = 8'h01 and `relay_hi` = 8'h00 at the next edge, whatever the value of `step`.
- R3: A cycle with `step` high, `start` and `rst` low, and the tap (`relay_hi[5]`) low shifts the 16-bit chain {relay_hi, relay_lo} left by one. `relay_lo[0]` takes 0 and `relay_hi[0]` takes the old `relay_lo[7]`.
- R4: A cycle with `rst`, `start` and `step` all low leaves both outputs unchanged.
- R5: A cycle with `step` high, `start` and `rst` low, and `relay_hi[5]` high clears `relay_hi` and sets `relay_lo[0]` in the same edge.
- R6: After a start, the pattern returns to `relay_lo` = 8'h01, `relay_hi` = 8'h00 after exactly 14 steps and repeats with that period.
- R7: At most one of the sixteen relay outputs is high at any time.
- R8: Steps applied after reset and before any start leave all outputs at zero, because only the start pulse and the tap inject bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads one active bit into lower bank stage 0 |
| step | input | 1 | Advance enable, sampled on the clock edge |
| relay_lo | output | 8 | Relay lines 50..57, bit i is line 50+i |
| relay_hi | output | 8 | Relay lines 60..67, bit i is line 60+i |

## Verification
The assertions check on every cycle that at most one output is high, that outputs hold when nothing is requested, that a step shifts the chain by one, that the tap wraps the bit in a single edge, and that start and reset load their fixed patterns. Only the bench scenarios show the full 14-step period, that idle stepping before any start keeps everything dark, and that the behaviour stays correct across random sequences that mix starts, resets and gaps between steps.

// File: rtl/relay_seq_pkg.sv
package relay_seq_pkg;
  localparam int unsigned BANK_W_DEF = 8;
  localparam int unsigned TAP_DEF    = 5;

  function automatic int unsigned loop_len(input int unsigned bank_w, input int unsigned tap);
    return bank_w + tap + 1;
  endfunction
endpackage

// File: rtl/relay_bank.sv
module relay_bank #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] LOAD_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  input  logic         flush,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= LOAD_VAL;
    else if (adv)   q <= flush ? '0 : {q[W-2:0], din};
  end

  // R4: a bank with no request keeps its contents
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(q));
endmodule

// File: rtl/relay_loop_ctrl.sv
module relay_loop_ctrl #(
  parameter int unsigned W   = 8,
  parameter int unsigned TAP = 5
) (
  input  logic [W-1:0] hi_q,
  input  logic [W-1:0] lo_q,
  output logic         lo_din,
  output logic         hi_din,
  output logic         hi_flush
);
  logic tap;
  always_comb begin
    tap      = hi_q[TAP];
    lo_din   = tap;
    hi_din   = lo_q[W-1];
    hi_flush = tap;
  end
endmodule

// File: rtl/relay_step_seq.sv
module relay_step_seq
  import relay_seq_pkg::*;
#(
  parameter int unsigned BANK_W = BANK_W_DEF,
  parameter int unsigned TAP    = TAP_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  output logic [BANK_W-1:0] relay_lo,
  output logic [BANK_W-1:0] relay_hi
);
  localparam int unsigned CHAIN_W = 2 * BANK_W;
  localparam int unsigned PERIOD  = loop_len(BANK_W, TAP);
  localparam logic [BANK_W-1:0] SEED = BANK_W'(1);

  logic lo_din, hi_din, hi_flush;
  logic [CHAIN_W-1:0] chain;

  relay_loop_ctrl #(.W(BANK_W), .TAP(TAP)) u_ctrl (
    .hi_q(relay_hi), .lo_q(relay_lo),
    .lo_din(lo_din), .hi_din(hi_din), .hi_flush(hi_flush)
  );

  relay_bank #(.W(BANK_W), .LOAD_VAL(SEED)) u_lo (
    .clk(clk), .rst(rst), .load(start), .adv(step),
    .flush(1'b0), .din(lo_din), .q(relay_lo)
  );

  relay_bank #(.W(BANK_W), .LOAD_VAL('0)) u_hi (
    .clk(clk), .rst(rst), .load(start), .adv(step),
    .flush(hi_flush), .din(hi_din), .q(relay_hi)
  );

  assign chain = {relay_hi, relay_lo};

  // R1: reset clears every line
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (chain == '0));
  // R2: start seeds a single bit in the lower bank
  p_start_seed_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (relay_lo == SEED && relay_hi == '0));
  // R3: a plain step shifts the chain by one
  p_shift_one_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !relay_hi[TAP]) |=> (chain == {$past(chain[CHAIN_W-2:0]), 1'b0}));
  // R5: the tap wraps the bit in one edge
  p_wrap_tap_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !start && relay_hi[TAP]) |=> (relay_hi == '0 && relay_lo == SEED));
  // R7: never more than one active line
  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chain));
  // R6: loop length sanity
  initial assert (PERIOD == BANK_W + TAP + 1 && TAP < BANK_W);
endmodule

// File: tb/relay_step_seq_tb.sv
module relay_step_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, start = 0, step = 0;
  logic [7:0] relay_lo, relay_hi;
  logic [15:0] model = '0;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  relay_step_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .step(step),
    .relay_lo(relay_lo), .relay_hi(relay_hi)
  );

  function automatic logic [15:0] next_val(input logic [15:0] cur,
                                           input logic r, input logic s, input logic st);
    if (r) return '0;
    if (s) return 16'h0001;
    if (!st) return cur;
    if (cur[13]) return 16'h0001;       // relay 65 = hi bit 5 = chain bit 13
    return {cur[14:0], 1'b0};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic s, input logic st, input string req);
    @(negedge clk);
    rst = r; start = s; step = st;
    model = next_val(model, r, s, st);
    @(posedge clk); #1;
    check(req, {relay_hi, relay_lo}, model);
    if (!$onehot0({relay_hi, relay_lo})) check("R7", {relay_hi, relay_lo}, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(1, 0, 0, "R1");
    cyc(1, 1, 1, "R1");
    // R8: stepping with nothing loaded
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, "R8");
    cyc(0, 1, 1, "R2");
    // R3 / R5 / R6: full loop twice
    for (int i = 0; i < 28; i++) cyc(0, 0, 1, (model[13]) ? "R5" : "R3");
    check("R6", {relay_hi, relay_lo}, 16'h0001);
    // R4: idle hold mid-sequence
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, "R3");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, "R4");
    // walk to tap and wrap directly
    while (!model[13]) cyc(0, 0, 1, "R3");
    cyc(0, 0, 0, "R4");
    cyc(0, 0, 1, "R5");
    check("R5", {relay_hi, relay_lo}, 16'h0001);
    // R2: restart mid-run
    for (int i = 0; i < 9; i++) cyc(0, 0, 1, "R3");
    cyc(0, 1, 0, "R2");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r, s, st;
      r  = ($urandom % 97) == 0;
      s  = ($urandom % 41) == 0;
      st = ($urandom % 3) != 0;
      cyc(r, s, st, r ? "R1" : s ? "R2" : !st ? "R4" : model[13] ? "R5" : "R3");
    end
    cyc(1, 0, 0, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule